// File: doc/BRIEF.md
# Inflight Request Tracking Table

This block keeps a record of merged memory requests that have been sent downstream and are still waiting for their response. Each record holds the lane that issued the merged request, the source ID that the merged response will carry, and one original request source ID for each lane. When the response comes back, the response logic uses its source ID to find the record. It then uses the stored per-lane IDs to send the reply back to each requester.

Records enter through a valid/ready write port. The table has no order: a lookup port compares a response source ID against every live record in the same cycle. It reports a hit and shows the matching record. When the consumer accepts the hit, that record is released. A write and a consuming lookup can both happen in one cycle.

The parameters are the lane count, the source ID width and the record count. The defaults are 4 lanes, 2-bit source IDs and 4 records.

Top module: `req_track_table`

## Requirements
- R1: A synchronous active-high reset empties the table. After reset `enqReady` is 1 and no lookup ID gives a hit.
- R2: `enqReady` is 1 while at least one record is free and 0 while all ENTRIES records are live.
- R3: A write attempt with `enqValid` high while the table is full is dropped. No later lookup finds its source ID, and `enqReady` stays 0.
- R4: `lookupValid` rises in the same cycle that some live record's response source ID equals `lookupId`. The outputs then show that record's lane, its response ID, and its request IDs. Lane i's ID occupies bits [i*SRC_W +: SRC_W].
- R5: A clock edge with `lookupValid` and `lookupReady` both 1 frees the shown record. From the next cycle, that record no longer answers lookups.
- R6: While `lookupReady` is 0, a hit leaves the record in place, and a repeated lookup finds it again.
- R7: A write and a consuming lookup in the same cycle both take effect. The new record is stored and the matched record is freed.
- R8: A write goes into the lowest-indexed free record. This can be seen because, among duplicate IDs, the lower-indexed record answers first.
- R9: When several live records carry the lookup ID, the lowest-indexed one is shown and freed first.
- R10: `enqReady` depends only on records that are live at the start of the cycle. A write offered to a full table is dropped even when a lookup frees a record in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enqValid | input | 1 | Write request |
| enqReady | output | 1 | A free record exists |
| enqLane | input | LANE_W | Lane that issued the merged request |
| enqRespId | input | SRC_W | Source ID of the merged response |
| enqReqIds | input | LANES*SRC_W | Original request ID per lane |
| lookupId | input | SRC_W | Response source ID to search for |
| lookupValid | output | 1 | A live record matches `lookupId` |
| lookupReady | input | 1 | Consumer accepts the hit; frees the record |
| lookupLane | output | LANE_W | Lane field of the matched record |
| lookupRespId | output | SRC_W | Response ID field of the matched record |
| lookupReqIds | output | LANES*SRC_W | Per-lane request IDs of the matched record |

## Verification
The vector walk fills the table with distinct IDs and then adds a duplicate ID. This separates a correct match from a plain first-live-record pick, and it exposes a wrong priority among duplicates. It then offers writes to a full table, both alone and alongside a consuming lookup. This separates a dropped write from a record that is silently stored or that takes a slot freed in the same cycle. Peeking lookups with ready low are interleaved with consuming ones, which shows whether release depends on the handshake. A final write that refills slot 0 while a duplicate sits in slot 3 shows whether new records go into the lowest free slot.

// File: rtl/req_track_pkg.sv
package req_track_pkg;

  // Strobes from the control to the datapath for one cycle
  typedef struct packed {
    logic allocEn;  // store the write payload into the chosen free slot
    logic freeEn;   // the shown record is being released
  } trackStrobe_t;

  function automatic int idxWidth(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/req_track_lowest.sv
module req_track_lowest #(
  parameter int WIDTH = 4,
  parameter int IDX_W = 2
) (
  input  logic [WIDTH-1:0] reqVec,
  output logic             found,
  output logic [IDX_W-1:0] idx
);

  // Lowest set bit wins: scan downward so the last hit is the smallest index
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (reqVec[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/req_track_ctrl.sv
module req_track_ctrl
  import req_track_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int IDX_W   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enqValid,
  output logic               enqReady,
  input  logic [ENTRIES-1:0] matchVec,
  input  logic               lookupReady,
  output logic               lookupValid,
  output logic [IDX_W-1:0]   allocIdx,
  output logic [IDX_W-1:0]   hitIdx,
  output trackStrobe_t       strobe
);

  logic [ENTRIES-1:0] validQ;
  logic [ENTRIES-1:0] freeVec;
  logic [ENTRIES-1:0] hitVec;
  logic               freeFound;
  logic               hitFound;

  assign freeVec = ~validQ;
  assign hitVec  = matchVec & validQ;

  req_track_lowest #(.WIDTH(ENTRIES), .IDX_W(IDX_W)) u_freePick (
    .reqVec(freeVec), .found(freeFound), .idx(allocIdx)
  );

  req_track_lowest #(.WIDTH(ENTRIES), .IDX_W(IDX_W)) u_hitPick (
    .reqVec(hitVec), .found(hitFound), .idx(hitIdx)
  );

  // Ready comes from the live bits only; a slot freed this cycle is not offered
  assign enqReady       = freeFound;
  assign lookupValid    = hitFound;
  assign strobe.allocEn = enqValid & freeFound;
  assign strobe.freeEn  = hitFound & lookupReady;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic setHere;
    logic clrHere;
    assign setHere = strobe.allocEn && (allocIdx == IDX_W'(g));
    assign clrHere = strobe.freeEn  && (hitIdx   == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (rst)          validQ[g] <= 1'b0;
      else if (setHere) validQ[g] <= 1'b1;
      else if (clrHere) validQ[g] <= 1'b0;
    end
  end

  AST_ALLOC_INTO_FREE: assert property (@(posedge clk) disable iff (rst)
    strobe.allocEn |-> !validQ[allocIdx]); // R8

  AST_FULL_STAYS_FULL: assert property (@(posedge clk) disable iff (rst)
    ((&validQ) && !strobe.freeEn) |=> !enqReady); // R3

  AST_FREED_LEAVES: assert property (@(posedge clk) disable iff (rst)
    strobe.freeEn |=> !validQ[$past(hitIdx)]); // R5

  AST_LIVE_COUNT: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (int'($countones(validQ)) ==
      int'($countones($past(validQ))) + int'($past(strobe.allocEn))
      - int'($past(strobe.freeEn)))); // R7

endmodule

// File: rtl/req_track_data.sv
module req_track_data
  import req_track_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int SRC_W   = 2,
  parameter int ENTRIES = 4,
  parameter int LANE_W  = 2,
  parameter int IDX_W   = 2
) (
  input  logic                   clk,
  input  trackStrobe_t           strobe,
  input  logic [IDX_W-1:0]       allocIdx,
  input  logic [LANE_W-1:0]      enqLane,
  input  logic [SRC_W-1:0]       enqRespId,
  input  logic [LANES*SRC_W-1:0] enqReqIds,
  input  logic [SRC_W-1:0]       lookupId,
  input  logic [IDX_W-1:0]       readIdx,
  output logic [ENTRIES-1:0]     matchVec,
  output logic [LANE_W-1:0]      rdLane,
  output logic [SRC_W-1:0]       rdRespId,
  output logic [LANES*SRC_W-1:0] rdReqIds
);

  logic [LANE_W-1:0]      laneQ [ENTRIES];
  logic [SRC_W-1:0]       respQ [ENTRIES];
  logic [LANES*SRC_W-1:0] reqQ  [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_store
    always_ff @(posedge clk) begin
      if (strobe.allocEn && (allocIdx == IDX_W'(g))) begin
        laneQ[g] <= enqLane;
        respQ[g] <= enqRespId;
        reqQ[g]  <= enqReqIds;
      end
    end
    assign matchVec[g] = (respQ[g] == lookupId);
  end

  assign rdLane   = laneQ[readIdx];
  assign rdRespId = respQ[readIdx];
  assign rdReqIds = reqQ[readIdx];

  // The datapath has no use for the release strobe
  logic unusedFree;
  assign unusedFree = strobe.freeEn;

endmodule

// File: rtl/req_track_table.sv
module req_track_table
  import req_track_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int SRC_W   = 2,
  parameter int ENTRIES = 4,
  localparam int LANE_W = idxWidth(LANES),
  localparam int IDX_W  = idxWidth(ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   enqValid,
  output logic                   enqReady,
  input  logic [LANE_W-1:0]      enqLane,
  input  logic [SRC_W-1:0]       enqRespId,
  input  logic [LANES*SRC_W-1:0] enqReqIds,
  input  logic [SRC_W-1:0]       lookupId,
  output logic                   lookupValid,
  input  logic                   lookupReady,
  output logic [LANE_W-1:0]      lookupLane,
  output logic [SRC_W-1:0]       lookupRespId,
  output logic [LANES*SRC_W-1:0] lookupReqIds
);

  trackStrobe_t       strobe;
  logic [ENTRIES-1:0] matchVec;
  logic [IDX_W-1:0]   allocIdx;
  logic [IDX_W-1:0]   hitIdx;

  req_track_ctrl #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .enqValid   (enqValid),
    .enqReady   (enqReady),
    .matchVec   (matchVec),
    .lookupReady(lookupReady),
    .lookupValid(lookupValid),
    .allocIdx   (allocIdx),
    .hitIdx     (hitIdx),
    .strobe     (strobe)
  );

  req_track_data #(
    .LANES(LANES), .SRC_W(SRC_W), .ENTRIES(ENTRIES),
    .LANE_W(LANE_W), .IDX_W(IDX_W)
  ) u_data (
    .clk      (clk),
    .strobe   (strobe),
    .allocIdx (allocIdx),
    .enqLane  (enqLane),
    .enqRespId(enqRespId),
    .enqReqIds(enqReqIds),
    .lookupId (lookupId),
    .readIdx  (hitIdx),
    .matchVec (matchVec),
    .rdLane   (lookupLane),
    .rdRespId (lookupRespId),
    .rdReqIds (lookupReqIds)
  );

  AST_HIT_CARRIES_ID: assert property (@(posedge clk) disable iff (rst)
    lookupValid |-> (lookupRespId == lookupId)); // R4

  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (!enqReady && enqValid) |=> ($stable(lookupLane) || !$past(lookupValid) || $past(lookupReady)
      || ($past(lookupId) != lookupId))); // R10

endmodule

// File: tb/test_req_track_table.sv
module test_req_track_table;

  localparam int LANES   = 4;
  localparam int SRC_W   = 2;
  localparam int ENTRIES = 4;

  typedef struct packed {
    logic       enqV;
    logic [1:0] lane;
    logic [1:0] resp;
    logic [7:0] req;
    logic       lkRdy;
    logic [1:0] lkId;
    logic       expRdy;
    logic       expHit;
    logic [1:0] expLane;
    logic [7:0] expReq;
    logic [3:0] tag;
  } vec_t;

  localparam int NVEC = 17;
  // Walk state notes use slot numbers; each row is checked before its clock edge
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 2'd0, 2'd0, 8'h00, 1'b0, 2'd0, 1'b1, 1'b0, 2'd0, 8'h00, 4'd2},  // R2 empty, write slot0
    '{1'b1, 2'd1, 2'd1, 8'h1B, 1'b0, 2'd0, 1'b1, 1'b1, 2'd0, 8'h00, 4'd6},  // R6 peek id0
    '{1'b1, 2'd2, 2'd2, 8'hE4, 1'b0, 2'd1, 1'b1, 1'b1, 2'd1, 8'h1B, 4'd6},  // R6 peek id1
    '{1'b1, 2'd3, 2'd1, 8'h55, 1'b0, 2'd2, 1'b1, 1'b1, 2'd2, 8'hE4, 4'd4},  // R4 dup id1 to slot3
    '{1'b1, 2'd0, 2'd3, 8'hFF, 1'b0, 2'd3, 1'b0, 1'b0, 2'd0, 8'h00, 4'd2},  // R2 full, write dropped
    '{1'b0, 2'd0, 2'd0, 8'h00, 1'b0, 2'd3, 1'b0, 1'b0, 2'd0, 8'h00, 4'd3},  // R3 dropped id3 absent
    '{1'b0, 2'd0, 2'd0, 8'h00, 1'b1, 2'd1, 1'b0, 1'b1, 2'd1, 8'h1B, 4'd9},  // R9 lowest dup wins
    '{1'b1, 2'd2, 2'd3, 8'h0F, 1'b0, 2'd1, 1'b1, 1'b1, 2'd3, 8'h55, 4'd5},  // R5 slot1 gone
    '{1'b1, 2'd1, 2'd0, 8'hAA, 1'b1, 2'd0, 1'b0, 1'b1, 2'd0, 8'h00, 4'd10}, // R10 write vs free
    '{1'b0, 2'd0, 2'd0, 8'h00, 1'b0, 2'd0, 1'b1, 1'b0, 2'd0, 8'h00, 4'd10}, // R10 id0 not stored
    '{1'b1, 2'd1, 2'd1, 8'hC3, 1'b1, 2'd3, 1'b1, 1'b1, 2'd2, 8'h0F, 4'd7},  // R7 write+consume
    '{1'b0, 2'd0, 2'd0, 8'h00, 1'b0, 2'd3, 1'b1, 1'b0, 2'd0, 8'h00, 4'd5},  // R5 id3 consumed
    '{1'b0, 2'd0, 2'd0, 8'h00, 1'b1, 2'd1, 1'b1, 1'b1, 2'd1, 8'hC3, 4'd8},  // R8 new write in slot0
    '{1'b0, 2'd0, 2'd0, 8'h00, 1'b1, 2'd1, 1'b1, 1'b1, 2'd3, 8'h55, 4'd9},  // R9 next dup
    '{1'b0, 2'd0, 2'd0, 8'h00, 1'b1, 2'd2, 1'b1, 1'b1, 2'd2, 8'hE4, 4'd5},  // R5 last record
    '{1'b0, 2'd0, 2'd0, 8'h00, 1'b0, 2'd1, 1'b1, 1'b0, 2'd0, 8'h00, 4'd5},  // R5 id1 empty
    '{1'b0, 2'd0, 2'd0, 8'h00, 1'b0, 2'd2, 1'b1, 1'b0, 2'd0, 8'h00, 4'd2}   // R2 ready again
  };

  logic                   clk = 1'b0;
  logic                   rst = 1'b1;
  logic                   enqValid = 1'b0;
  logic                   enqReady;
  logic [1:0]             enqLane = '0;
  logic [SRC_W-1:0]       enqRespId = '0;
  logic [LANES*SRC_W-1:0] enqReqIds = '0;
  logic [SRC_W-1:0]       lookupId = '0;
  logic                   lookupValid;
  logic                   lookupReady = 1'b0;
  logic [1:0]             lookupLane;
  logic [SRC_W-1:0]       lookupRespId;
  logic [LANES*SRC_W-1:0] lookupReqIds;

  int checkCnt = 0;
  int failCnt  = 0;
  logic runDone = 1'b0;

  always #4 clk = ~clk;

  req_track_table #(.LANES(LANES), .SRC_W(SRC_W), .ENTRIES(ENTRIES)) i_req_track_table (
    .clk, .rst, .enqValid, .enqReady, .enqLane, .enqRespId, .enqReqIds,
    .lookupId, .lookupValid, .lookupReady, .lookupLane, .lookupRespId, .lookupReqIds
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic ev, input logic [1:0] ln, input logic [1:0] rs,
                       input logic [7:0] rq, input logic lr, input logic [1:0] li);
    @(negedge clk);
    enqValid = ev; enqLane = ln; enqRespId = rs; enqReqIds = rq;
    lookupReady = lr; lookupId = li;
    #1;
  endtask

  task automatic expectEmpty(input string req);
    for (int id = 0; id < 4; id++) begin
      drive(1'b0, 2'd0, 2'd0, 8'h00, 1'b0, 2'(id));
      chk(req, "lookupValid on empty", 32'(lookupValid), 32'd0);
    end
    chk(req, "enqReady on empty", 32'(enqReady), 32'd1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1: reset state
    expectEmpty("R1");

    // Vector walk
    for (int v = 0; v < NVEC; v++) begin
      string tg;
      tg = $sformatf("R%0d vec%0d", VECS[v].tag, v);
      drive(VECS[v].enqV, VECS[v].lane, VECS[v].resp, VECS[v].req, VECS[v].lkRdy, VECS[v].lkId);
      chk((VECS[v].tag == 4'd2) ? "R2" : tg, "enqReady", 32'(enqReady), 32'(VECS[v].expRdy));
      chk(tg, "lookupValid", 32'(lookupValid), 32'(VECS[v].expHit));
      if (VECS[v].expHit) begin
        chk(tg, "lookupLane", 32'(lookupLane), 32'(VECS[v].expLane));
        chk(tg, "lookupRespId", 32'(lookupRespId), 32'(VECS[v].lkId));
        chk(tg, "lookupReqIds", 32'(lookupReqIds), 32'(VECS[v].expReq));
      end
    end

    // R1: reset in the middle of traffic drops all records
    drive(1'b1, 2'd2, 2'd0, 8'h12, 1'b0, 2'd0);
    drive(1'b1, 2'd3, 2'd1, 8'h34, 1'b0, 2'd0);
    chk("R1", "record before reset", 32'(lookupValid), 32'd1);
    drive(1'b0, 2'd0, 2'd0, 8'h00, 1'b0, 2'd0);
    rst = 1'b1;
    drive(1'b0, 2'd0, 2'd0, 8'h00, 1'b0, 2'd0);
    rst = 1'b0;
    expectEmpty("R1");

    // R2: ready falls exactly at the fourth record
    for (int k = 0; k < ENTRIES; k++) begin
      drive(1'b1, 2'(k), 2'(k), 8'(k * 17), 1'b0, 2'd0);
      chk("R2", "enqReady while filling", 32'(enqReady), 32'd1);
    end
    drive(1'b0, 2'd0, 2'd0, 8'h00, 1'b0, 2'd0);
    chk("R2", "enqReady when full", 32'(enqReady), 32'd0);

    runDone = 1'b1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!runDone) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

endmodule